// File: doc/BRIEF.md
# Base/Mask Address Route Decoder

This block holds a bank of programmable routing descriptors for an on-chip interconnect and uses them to steer memory requests. Each descriptor is a 64-bit register. It holds a 3-bit destination port, a cycle-type selector, a 20-bit page base and a 20-bit page mask. Software writes and reads the descriptors through a simple register port. Descriptor i sits at register address `REG_BASE + i`.

For every request, the block takes a 32-bit physical address and a one-bit special-cycle flag. It compares them with all descriptors in parallel. Address bits 31:12 are ANDed with a descriptor's mask and compared for equality with its base. The descriptor's cycle-type bit must also match the special flag. When more than one descriptor hits, the lowest index wins. The block reports a hit flag, the winner's port and the winner's index. The result is registered and appears one clock after the request.

Top module: `route_decoder`

## Requirements
- R1: After reset every descriptor reads 0x000000FF_FFF00000 (base all ones, mask all zeros), and no request of either cycle type hits.
- R2: Field layout: bits 63:61 hold the destination port (binary 0..7), bit 60 holds the cycle type, bits 39:20 hold the base and bits 19:0 hold the mask. A written value reads back with these fields unchanged.
- R3: Bits 59:40 always read as zero, and values written to them are discarded.
- R4: A descriptor's address condition holds when (addr[31:12] AND mask) equals base. A mask bit of 1 includes that address bit in the compare, and a mask bit of 0 excludes it.
- R5: A descriptor whose cycle-type bit is 0 hits only requests with `req_special`=0. A descriptor whose cycle-type bit is 1 hits only requests with `req_special`=1.
- R6: When several descriptors hit, the one with the lowest index is reported. `rsp_port` carries its port field and `rsp_index` carries its index.
- R7: When no descriptor hits, `rsp_hit`=0, `rsp_port`=0 and `rsp_index`=0.
- R8: `rsp_valid` is high in exactly the cycle after each cycle in which `req_valid` is high. The response fields are loaded only on a request.
- R9: A request presented in the same cycle as a descriptor write is decoded with the old contents. Requests in later cycles see the new contents.
- R10: A read of an address outside `REG_BASE .. REG_BASE+NUM_DESC-1` returns zero, and a write to such an address changes no descriptor.
- R11: The descriptor count `NUM_DESC` is a parameter. `rsp_index` is wide enough to name every descriptor, including indices of 8 and above when there are 10 descriptors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register address |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data (combinational from reg_addr) |
| req_valid | input | 1 | Request strobe |
| req_addr | input | 32 | Request physical address |
| req_special | input | 1 | Request special-cycle flag |
| rsp_valid | output | 1 | Result strobe, one cycle after req_valid |
| rsp_hit | output | 1 | A descriptor matched |
| rsp_port | output | 3 | Destination port of the winning descriptor |
| rsp_index | output | IDX_W | Index of the winning descriptor |

## Verification
The bench builds the block with ten descriptors at register base 0x20. This makes 4-bit indices and a winner at index 9 reachable, and it puts the first address past the bank at 0x2A. Overlapping descriptors test lowest-index priority, and a catch-all special-cycle descriptor tests the cycle-type qualifier. One descriptor is written with all ones to exercise the reserved bits. Another is written in the same cycle as a request, to pin down when a write becomes visible to decoding.

// File: rtl/route_pkg.sv
package route_pkg;
  localparam int PORT_W = 3;
  localparam int PAGE_W = 20;
  localparam int PAGE_LSB = 12;

  typedef struct packed {
    logic [PORT_W-1:0] port;
    logic              special;
    logic [PAGE_W-1:0] base;
    logic [PAGE_W-1:0] mask;
  } desc_t;

  localparam desc_t DESC_RESET = '{port: '0, special: 1'b0, base: '1, mask: '0};

  function automatic logic [63:0] desc_to_word(input desc_t d);
    return {d.port, d.special, 20'h0, d.base, d.mask};
  endfunction

  function automatic desc_t word_to_desc(input logic [63:0] w);
    desc_t d;
    d.port    = w[63:61];
    d.special = w[60];
    d.base    = w[39:20];
    d.mask    = w[19:0];
    return d;
  endfunction
endpackage

// File: rtl/route_desc_bank.sv
module route_desc_bank
  import route_pkg::*;
#(
  parameter int NUM_DESC = 6,
  parameter int REG_AW = 16,
  parameter logic [REG_AW-1:0] REG_BASE = 16'h0020
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wen,
  input  logic [REG_AW-1:0]   reg_addr,
  input  logic [63:0]         reg_wdata,
  output logic [63:0]         reg_rdata,
  output desc_t [NUM_DESC-1:0] descs
);
  localparam logic [REG_AW-1:0] COUNT_A = REG_AW'(NUM_DESC);

  logic [REG_AW-1:0] offset;
  logic              in_range;
  desc_t             wr_desc;

  always_comb begin
    offset   = reg_addr - REG_BASE;
    in_range = (reg_addr >= REG_BASE) && (offset < COUNT_A);
    wr_desc  = word_to_desc(reg_wdata);
  end

  for (genvar i = 0; i < NUM_DESC; i++) begin : g_entry
    logic  wr_en;
    desc_t d_q;
    desc_t d_nxt;

    always_comb begin
      wr_en = reg_wen && in_range && (offset == REG_AW'(i));
      d_nxt = wr_en ? wr_desc : d_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) d_q <= DESC_RESET;
      else        d_q <= d_nxt;
    end

    assign descs[i] = d_q;
  end

  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < NUM_DESC; i++) begin
      if (in_range && offset == REG_AW'(i)) reg_rdata = desc_to_word(descs[i]);
    end
  end
endmodule

// File: rtl/route_match.sv
module route_match
  import route_pkg::*;
(
  input  desc_t       desc,
  input  logic [31:0] addr,
  input  logic        special,
  output logic        hit
);
  logic [PAGE_W-1:0] page;

  always_comb begin
    page = addr[PAGE_LSB +: PAGE_W];
    hit  = (special == desc.special) && ((page & desc.mask) == desc.base);
  end
endmodule

// File: rtl/route_prio_pick.sv
module route_prio_pick #(
  parameter int NUM_DESC = 6,
  localparam int IDX_W = (NUM_DESC > 1) ? $clog2(NUM_DESC) : 1
) (
  input  logic [NUM_DESC-1:0] hits,
  output logic                any_hit,
  output logic [IDX_W-1:0]    win_idx
);
  always_comb begin
    any_hit = |hits;
    win_idx = '0;
    for (int i = NUM_DESC - 1; i >= 0; i--) begin
      if (hits[i]) win_idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/route_decoder.sv
module route_decoder
  import route_pkg::*;
#(
  parameter int NUM_DESC = 6,
  parameter int REG_AW = 16,
  parameter logic [REG_AW-1:0] REG_BASE = 16'h0020,
  localparam int IDX_W = (NUM_DESC > 1) ? $clog2(NUM_DESC) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wen,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [63:0]       reg_wdata,
  output logic [63:0]       reg_rdata,
  input  logic              req_valid,
  input  logic [31:0]       req_addr,
  input  logic              req_special,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [2:0]        rsp_port,
  output logic [IDX_W-1:0]  rsp_index
);
  desc_t [NUM_DESC-1:0] descs;
  logic  [NUM_DESC-1:0] hits;
  logic                 any_hit;
  logic [IDX_W-1:0]     win_idx;
  logic [PORT_W-1:0]    win_port;

  logic                 valid_q, valid_nxt;
  logic                 hit_q, hit_nxt;
  logic [PORT_W-1:0]    port_q, port_nxt;
  logic [IDX_W-1:0]     idx_q, idx_nxt;

  route_desc_bank #(
    .NUM_DESC(NUM_DESC), .REG_AW(REG_AW), .REG_BASE(REG_BASE)
  ) u_bank (
    .clk(clk), .rst_n(rst_n), .reg_wen(reg_wen), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .descs(descs)
  );

  for (genvar i = 0; i < NUM_DESC; i++) begin : g_match
    route_match u_match (
      .desc(descs[i]), .addr(req_addr), .special(req_special), .hit(hits[i])
    );
  end

  route_prio_pick #(.NUM_DESC(NUM_DESC)) u_pick (
    .hits(hits), .any_hit(any_hit), .win_idx(win_idx)
  );

  always_comb begin
    win_port = '0;
    for (int i = 0; i < NUM_DESC; i++) begin
      if (any_hit && win_idx == IDX_W'(i)) win_port = descs[i].port;
    end
  end

  // next-state: response fields load only when a request is presented
  always_comb begin
    valid_nxt = req_valid;
    hit_nxt   = hit_q;
    port_nxt  = port_q;
    idx_nxt   = idx_q;
    if (req_valid) begin
      hit_nxt  = any_hit;
      port_nxt = win_port;
      idx_nxt  = win_idx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      hit_q   <= 1'b0;
      port_q  <= '0;
      idx_q   <= '0;
    end else begin
      valid_q <= valid_nxt;
      hit_q   <= hit_nxt;
      port_q  <= port_nxt;
      idx_q   <= idx_nxt;
    end
  end

  assign rsp_valid = valid_q;
  assign rsp_hit   = hit_q;
  assign rsp_port  = port_q;
  assign rsp_index = idx_q;
endmodule

// File: rtl/route_decoder_chk.sv
module route_decoder_chk #(
  parameter int NUM_DESC = 6,
  parameter int REG_AW = 16,
  parameter logic [REG_AW-1:0] REG_BASE = 16'h0020,
  localparam int IDX_W = (NUM_DESC > 1) ? $clog2(NUM_DESC) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [REG_AW-1:0] reg_addr,
  input logic [63:0]       reg_rdata,
  input logic              req_valid,
  input logic              rsp_valid,
  input logic              rsp_hit,
  input logic [2:0]        rsp_port,
  input logic [IDX_W-1:0]  rsp_index
);
  localparam logic [REG_AW:0] LO_A = {1'b0, REG_BASE};
  localparam logic [REG_AW:0] HI_A = LO_A + (REG_AW+1)'(NUM_DESC);

  // R8
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  // R8
  rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  // R7
  miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (rsp_port == 3'd0 && rsp_index == '0));

  // R11
  index_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_hit) |-> ({1'b0, rsp_index} < (IDX_W+1)'(NUM_DESC)));

  // R3
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[59:40] == 20'h0);

  // R10
  unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, reg_addr} < LO_A || {1'b0, reg_addr} >= HI_A) |-> reg_rdata == 64'h0);
endmodule

bind route_decoder route_decoder_chk #(
  .NUM_DESC(NUM_DESC), .REG_AW(REG_AW), .REG_BASE(REG_BASE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
  .req_valid(req_valid), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
  .rsp_port(rsp_port), .rsp_index(rsp_index)
);

// File: tb/route_decoder_test.sv
module route_decoder_test;
  localparam int CLK_PERIOD = 10;
  localparam int ND = 10;
  localparam int AW = 16;
  localparam logic [AW-1:0] RB = 16'h0020;
  localparam logic [63:0] RST_WORD = 64'h000000FF_FFF00000;

  logic clk = 1'b0;
  logic rst_n;
  logic reg_wen;
  logic [AW-1:0] reg_addr;
  logic [63:0] reg_wdata, reg_rdata;
  logic req_valid, req_special;
  logic [31:0] req_addr;
  logic rsp_valid, rsp_hit;
  logic [2:0] rsp_port;
  logic [3:0] rsp_index;

  int n_vec = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  route_decoder #(.NUM_DESC(ND), .REG_AW(AW), .REG_BASE(RB)) uut (
    .clk(clk), .rst_n(rst_n), .reg_wen(reg_wen), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_valid(req_valid),
    .req_addr(req_addr), .req_special(req_special), .rsp_valid(rsp_valid),
    .rsp_hit(rsp_hit), .rsp_port(rsp_port), .rsp_index(rsp_index)
  );

  // {addr, special, exp_hit, exp_port, exp_index}
  localparam logic [40:0] VEC [10] = '{
    {32'h1000_0ABC, 1'b0, 1'b1, 3'd3, 4'd0},
    {32'h1000_5000, 1'b0, 1'b1, 3'd5, 4'd1},
    {32'h1001_0000, 1'b0, 1'b0, 3'd0, 4'd0},
    {32'h1000_0000, 1'b1, 1'b1, 3'd6, 4'd2},
    {32'h4123_4567, 1'b0, 1'b1, 3'd1, 4'd4},
    {32'h8000_0000, 1'b0, 1'b1, 3'd7, 4'd9},
    {32'hFFFF_F000, 1'b0, 1'b1, 3'd7, 4'd9},
    {32'h0000_0000, 1'b0, 1'b0, 3'd0, 4'd0},
    {32'hFFFF_FFFF, 1'b1, 1'b1, 3'd6, 4'd2},
    {32'h4000_0000, 1'b1, 1'b1, 3'd6, 4'd2}
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] mk(input logic [2:0] p, input logic s,
                                     input logic [19:0] b, input logic [19:0] m);
    return {p, s, 20'h0, b, m};
  endfunction

  task automatic wr(input logic [AW-1:0] a, input logic [63:0] d);
    reg_wen = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); @(negedge clk);
    reg_wen = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [63:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  // result packed {valid, hit, port, index}
  task automatic req(input logic [31:0] a, input logic s, output logic [8:0] r);
    req_valid = 1'b1; req_addr = a; req_special = s;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    r = {rsp_valid, rsp_hit, rsp_port, rsp_index};
  endtask

  initial begin
    for (int c = 0; c < 20000; c++) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog R8 actual=timeout expected=finish");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [63:0] d;
    logic [8:0]  r;
    rst_n = 1'b0; reg_wen = 1'b0; reg_addr = '0; reg_wdata = '0;
    req_valid = 1'b0; req_addr = '0; req_special = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset contents and no hit after reset
    for (int i = 0; i < ND; i++) begin
      rd(RB + AW'(i), d);
      check("R1 reset value", d, RST_WORD);
    end
    req(32'hFFFF_F000, 1'b0, r);
    check("R1 no hit normal", 64'(r), 64'({1'b1, 1'b0, 3'd0, 4'd0}));
    req(32'h0000_0000, 1'b1, r);
    check("R1 no hit special", 64'(r), 64'({1'b1, 1'b0, 3'd0, 4'd0}));
    @(negedge clk);
    check("R8 valid drops", 64'(rsp_valid), 64'd0);

    // descriptor programming (R2 readback)
    wr(RB + 0, mk(3'd3, 1'b0, 20'h10000, 20'hFFFFF));
    wr(RB + 1, mk(3'd5, 1'b0, 20'h10000, 20'hFFFF0));
    wr(RB + 2, mk(3'd6, 1'b1, 20'h00000, 20'h00000));
    wr(RB + 4, mk(3'd1, 1'b0, 20'h40000, 20'hF0000));
    wr(RB + 9, mk(3'd7, 1'b0, 20'h80000, 20'h80000));
    rd(RB + 1, d);
    check("R2 readback", d, mk(3'd5, 1'b0, 20'h10000, 20'hFFFF0));
    rd(RB + 9, d);
    check("R2 readback idx9", d, mk(3'd7, 1'b0, 20'h80000, 20'h80000));

    // table: R4 masking, R5 cycle type, R6 priority, R7 miss, R11 index 9
    for (int v = 0; v < 10; v++) begin
      req(VEC[v][40:9], VEC[v][8], r);
      check("R4/R5/R6/R7/R11 vector", 64'(r), 64'({1'b1, VEC[v][7:0]}));
    end

    // R3: reserved bits discarded
    wr(RB + 5, 64'hFFFF_FFFF_FFFF_FFFF);
    rd(RB + 5, d);
    check("R3 reserved zero", d, 64'hF000_00FF_FFFF_FFFF);
    // R6: idx2 and idx5 both hit a special request; lower wins
    req(32'hFFFF_F000, 1'b1, r);
    check("R6 lowest wins", 64'(r), 64'({1'b1, 1'b1, 3'd6, 4'd2}));

    // R10: unmapped addresses
    wr(RB + AW'(ND), 64'h1234_0000_5678_9ABC);
    rd(RB + AW'(ND), d);
    check("R10 read past bank", d, 64'h0);
    rd(RB - 1, d);
    check("R10 read below bank", d, 64'h0);
    rd(RB + 9, d);
    check("R10 neighbor intact", d, mk(3'd7, 1'b0, 20'h80000, 20'h80000));

    // R9: write and request in the same cycle
    reg_wen = 1'b1; reg_addr = RB + 3; reg_wdata = mk(3'd2, 1'b0, 20'h30000, 20'hFFFFF);
    req_valid = 1'b1; req_addr = 32'h3000_0000; req_special = 1'b0;
    @(posedge clk); @(negedge clk);
    reg_wen = 1'b0; req_valid = 1'b0;
    check("R9 same-cycle old", 64'({rsp_valid, rsp_hit, rsp_port, rsp_index}),
          64'({1'b1, 1'b0, 3'd0, 4'd0}));
    req(32'h3000_0000, 1'b0, r);
    check("R9 next-cycle new", 64'(r), 64'({1'b1, 1'b1, 3'd2, 4'd3}));

    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule